// File: doc/BRIEF.md
# SPI Serial Memory Command and Protection Controller

This block is the SPI slave front end of a 2048-byte serial memory. Each transaction opens with CS# going low and an 8-bit command shifted in on SCK. Some commands act at once: they arm or disarm the write latch, or set or clear a software flag. Other commands move data. The block can stream the status byte back to the host. It can read the array from a start address and keep returning bytes for as long as SCK runs. It can also take a burst of write data into the array. The array and its nonvolatile programming sit behind a simple synchronous memory port and are outside the block.

Before any byte goes to the array, the block checks it against two things. The first is the 2-bit lock selector, which fences off the top quarter, the top half or all of the array. The second is the write latch. Status writes have their own gate: the write latch, a status-lock enable bit and the active-low guard pin. The guard pin and the status-lock bit together can freeze the status byte while the array's unlocked part stays writable.

SCK, CS#, MOSI and the guard pin are taken as already synchronous to `clk`. SCK high and low phases must each last at least 4 `clk` cycles. The external memory returns read data one cycle after `mem_re`.

Top module: `spi_mem_ctrl`

## Requirements
- R1: A command byte is 8 bits, taken from MOSI on SCK rising edges while CS# is low, most significant bit first. If CS# rises on a partial byte, that byte is dropped and has no effect. `miso_oe` is 1 exactly while CS# is low, and the memory port issues no access while CS# is high.
- R2: After reset the write latch and the flag are 0. Command 0x06 sets the write latch. Command 0x00 sets the flag. Command 0x04 clears both.
- R3: Command 0x05 returns the status byte on every following byte of the transaction. Its bits are: bit0 write latch, bits 2:1 lock selector, bits 4:3 watchdog select, bit5 flag, bit7 status-lock enable. Bit6 reads 0. Data leaves MISO on SCK falling edges, most significant bit first.
- R4: Command 0x03 takes two address bytes, high byte first. Only the low 11 bits of that address are used. The block then returns one array byte per further SCK byte, starting at that address and counting up, and wraps from 0x7FF to 0x000. Locked addresses read normally.
- R5: Command 0x02 takes two address bytes in the same form. Each further complete byte is written to the next address, counting up with the same wrap.
- R6: Lock selector 00 locks nothing, 01 locks 0x600–0x7FF, 10 locks 0x400–0x7FF and 11 locks 0x000–0x7FF. A write to a locked address leaves the array unchanged.
- R7: While the write latch is 0, neither the array nor any status field changes on a write command.
- R8: When the write latch is 1, status-lock enable is 1 and the guard pin is low, a status write changes nothing. Unlocked array addresses still accept writes in this state.
- R9: Command 0x01 followed by one byte updates status-lock enable, watchdog select and lock selector from bits 7 and 4:1 of that byte. This happens when the write latch is 1 and either status-lock enable is 0 or the guard pin is high. Bits 5 and 0 of the written byte have no effect.
- R10: The write latch clears when CS# rises, if the transaction completed a status-write byte or at least one array-write data byte. This holds whether or not the write was refused. It does not clear after reads, or after a write that ended before its first data byte.
- R11: Unknown command bytes are ignored. Bytes that follow a one-byte command in the same transaction are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | synchronous active-low reset |
| sck | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI serial data in |
| miso | output | 1 | SPI serial data out |
| miso_oe | output | 1 | pad enable for MISO; high-impedance when 0 |
| guard_n | input | 1 | active-low hardware guard for status writes |
| mem_addr | output | 11 | memory address |
| mem_wdata | output | 8 | memory write data |
| mem_we | output | 1 | one-cycle write strobe |
| mem_re | output | 1 | one-cycle read strobe |
| mem_rdata | input | 8 | read data, valid the cycle after mem_re |

## Verification
The bench sweeps all 32 combinations of lock selector, status-lock enable, guard level and write latch. For each combination it tries burst writes that straddle each lock boundary and the top-of-array wrap, then reads every byte back. A wrong boundary compare would corrupt or skip the byte next to 0x400 or 0x600, and a missing wrap would return data from the wrong end of the array. Status writes are tried in every combination with bits 5 and 0 set. This exposes a gate that ignores the guard pin, and a write that leaks into the flag or the latch. The bench also drops CS# after a partial byte, after a bare address and after a read. A latch that clears too eagerly, or a partial byte that executes, shows up as the wrong status value.

// File: rtl/spi_mem_pkg.sv
// Shared command codes, transaction phases and the status record.
package spi_mem_pkg;

    localparam logic [7:0] OP_FLAG_SET = 8'h00;
    localparam logic [7:0] OP_STAT_WR  = 8'h01;
    localparam logic [7:0] OP_ARR_WR   = 8'h02;
    localparam logic [7:0] OP_ARR_RD   = 8'h03;
    localparam logic [7:0] OP_DISARM   = 8'h04;
    localparam logic [7:0] OP_STAT_RD  = 8'h05;
    localparam logic [7:0] OP_ARM      = 8'h06;

    typedef enum logic [2:0] {
        PH_OPC, PH_ADR_HI, PH_ADR_LO, PH_RD, PH_WR, PH_SR_RD, PH_SR_WR, PH_IGNORE
    } phase_e;

    typedef struct packed {
        logic       sr_lock_en;
        logic       flag;
        logic [1:0] wdog_sel;
        logic [1:0] lock_sel;
        logic       wlatch;
    } stat_t;

    // Pack the status record into the byte the host reads.
    function automatic logic [7:0] stat_to_byte(input stat_t s);
        return {s.sr_lock_en, 1'b0, s.flag, s.wdog_sel, s.lock_sel, s.wlatch};
    endfunction

endpackage

// File: rtl/spi_mem_shift.sv
// SPI mode-0 bit engine: detects SCK edges on the system clock, assembles
// received bytes and serialises the loaded transmit byte.
// Assumes sck/cs_n/mosi are synchronous to clk and each SCK phase lasts
// at least 4 clk cycles.
module spi_mem_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic       load_stb,
    input  logic [7:0] load_byte,
    output logic       rx_stb,
    output logic [7:0] rx_byte,
    output logic       cs_rise,
    output logic       miso_bit
);
    logic       sck_q, cs_q;
    logic [2:0] bit_cnt;
    logic [6:0] sh;
    logic [7:0] tx;
    logic       rise, fall;

    assign rise    = sck & ~sck_q & ~cs_n;
    assign fall    = ~sck & sck_q & ~cs_n;
    assign rx_stb  = rise & (bit_cnt == 3'd7);
    assign rx_byte = {sh, mosi};
    assign cs_rise = cs_n & ~cs_q;

    // Previous-cycle copies of SCK and CS# for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    // Receive shift register and bit counter, cleared whenever deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            bit_cnt <= 3'd0;
            sh      <= 7'd0;
        end else if (rise) begin
            sh      <= {sh[5:0], mosi};
            bit_cnt <= bit_cnt + 3'd1;
        end
    end

    // Transmit byte holder, loaded by the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx <= 8'd0;
        else if (load_stb) tx <= load_byte;
    end

    // MISO update on SCK falling edges, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) miso_bit <= 1'b0;
        else if (fall)      miso_bit <= tx[3'd7 - bit_cnt];
    end

endmodule

// File: rtl/spi_mem_guard.sv
// Write-permission logic: array writes need the latch and an unlocked
// address; status writes need the latch and either the status-lock enable
// clear or the guard pin high. Purely combinational.
module spi_mem_guard #(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        lock_sel,
    input  logic              wlatch,
    input  logic              sr_lock_en,
    input  logic              guard_n,
    output logic              arr_ok,
    output logic              stat_ok
);
    logic in_lock;

    // Locked region is the top quarter, the top half or everything.
    always_comb begin
        case (lock_sel)
            2'b00:   in_lock = 1'b0;
            2'b01:   in_lock = &addr[ADDR_W-1 -: 2];
            2'b10:   in_lock = addr[ADDR_W-1];
            default: in_lock = 1'b1;
        endcase
    end

    assign arr_ok  = wlatch & ~in_lock;
    assign stat_ok = wlatch & (~sr_lock_en | guard_n);

endmodule

// File: rtl/spi_mem_seq.sv
// Command sequencer: decodes command bytes, holds the status record and
// the running address, and drives the registered memory port.
// Assumes the memory returns read data one cycle after mem_re.
module spi_mem_seq
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              cs_rise,
    input  logic              rx_stb,
    input  logic [7:0]        rx_byte,
    input  logic              arr_ok,
    input  logic              stat_ok,
    input  logic              guard_n,
    input  logic [7:0]        mem_rdata,
    output stat_t             st,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              load_stb,
    output logic [7:0]        load_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re
);
    localparam int HI_W  = ADDR_W - 8;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HALF  = DEPTH / 2;
    localparam int Q3    = (DEPTH / 4) * 3;

    phase_e            ph;
    logic              rd_op, wr_done, rd_wait, stat_load;
    logic [ADDR_W-1:0] addr, lo_base;

    assign cur_addr  = addr;
    assign lo_base   = {addr[ADDR_W-1:8], rx_byte};
    assign load_stb  = stat_load | rd_wait;
    assign load_byte = rd_wait ? mem_rdata : stat_to_byte(st);

    // Phase machine, status record, address counter and memory strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= PH_OPC;
            addr      <= '0;
            rd_op     <= 1'b0;
            st        <= '0;
            wr_done   <= 1'b0;
            rd_wait   <= 1'b0;
            stat_load <= 1'b0;
            mem_we    <= 1'b0;
            mem_re    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we    <= 1'b0;
            mem_re    <= 1'b0;
            rd_wait   <= mem_re;
            stat_load <= 1'b0;
            if (cs_n) begin
                ph <= PH_OPC;
                if (cs_rise) begin
                    if (wr_done) st.wlatch <= 1'b0;
                    wr_done <= 1'b0;
                end
            end else if (rx_stb) begin
                case (ph)
                    PH_OPC: begin
                        ph <= PH_IGNORE;
                        case (rx_byte)
                            OP_ARM:      st.wlatch <= 1'b1;
                            OP_FLAG_SET: st.flag   <= 1'b1;
                            OP_DISARM: begin
                                st.wlatch <= 1'b0;
                                st.flag   <= 1'b0;
                            end
                            OP_STAT_RD: begin
                                stat_load <= 1'b1;
                                ph        <= PH_SR_RD;
                            end
                            OP_STAT_WR: ph <= PH_SR_WR;
                            OP_ARR_RD: begin
                                rd_op <= 1'b1;
                                ph    <= PH_ADR_HI;
                            end
                            OP_ARR_WR: begin
                                rd_op <= 1'b0;
                                ph    <= PH_ADR_HI;
                            end
                            default: ;
                        endcase
                    end
                    PH_ADR_HI: begin
                        addr[ADDR_W-1:8] <= rx_byte[HI_W-1:0];
                        ph               <= PH_ADR_LO;
                    end
                    PH_ADR_LO: begin
                        if (rd_op) begin
                            mem_re   <= 1'b1;
                            mem_addr <= lo_base;
                            addr     <= lo_base + 1'b1;
                            ph       <= PH_RD;
                        end else begin
                            addr <= lo_base;
                            ph   <= PH_WR;
                        end
                    end
                    PH_RD: begin
                        mem_re   <= 1'b1;
                        mem_addr <= addr;
                        addr     <= addr + 1'b1;
                    end
                    PH_WR: begin
                        wr_done <= 1'b1;
                        addr    <= addr + 1'b1;
                        if (arr_ok) begin
                            mem_we    <= 1'b1;
                            mem_addr  <= addr;
                            mem_wdata <= rx_byte;
                        end
                    end
                    PH_SR_RD: stat_load <= 1'b1;
                    PH_SR_WR: begin
                        wr_done <= 1'b1;
                        ph      <= PH_IGNORE;
                        if (stat_ok) begin
                            st.sr_lock_en <= rx_byte[7];
                            st.wdog_sel   <= rx_byte[4:3];
                            st.lock_sel   <= rx_byte[2:1];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: the memory port is quiet while deselected.
    assert_port_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> $past(!cs_n));

    // R7: an array write only issues while the latch is set.
    assert_we_needs_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(st.wlatch));

    // R6: an issued write address lies below the locked bound.
    assert_we_outside_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (st.lock_sel == 2'b00)
                || (st.lock_sel == 2'b01 && 32'(mem_addr) < Q3)
                || (st.lock_sel == 2'b10 && 32'(mem_addr) < HALF));

    // R8: status fields change only through an open status gate.
    assert_stat_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({st.sr_lock_en, st.wdog_sel, st.lock_sel})
        |-> $past(st.wlatch && (!st.sr_lock_en || guard_n)));

    // R10: a finished write transaction drops the latch.
    assert_latch_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && wr_done) |=> !st.wlatch);

endmodule

// File: rtl/spi_mem_ctrl.sv
// Top level: ties the SPI bit engine, the command sequencer and the write
// permission logic together and drives the MISO pad enable.
module spi_mem_ctrl
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    input  logic              guard_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata
);
    logic              rx_stb, cs_rise, load_stb, arr_ok, stat_ok;
    logic [7:0]        rx_byte, load_byte;
    logic [ADDR_W-1:0] cur_addr;
    stat_t             st;

    assign miso_oe = ~cs_n;

    spi_mem_shift i_shift (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .load_stb(load_stb), .load_byte(load_byte),
        .rx_stb(rx_stb), .rx_byte(rx_byte), .cs_rise(cs_rise), .miso_bit(miso)
    );

    spi_mem_seq #(.ADDR_W(ADDR_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_rise(cs_rise),
        .rx_stb(rx_stb), .rx_byte(rx_byte), .arr_ok(arr_ok), .stat_ok(stat_ok),
        .guard_n(guard_n), .mem_rdata(mem_rdata), .st(st), .cur_addr(cur_addr),
        .load_stb(load_stb), .load_byte(load_byte), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re)
    );

    spi_mem_guard #(.ADDR_W(ADDR_W)) i_guard (
        .addr(cur_addr), .lock_sel(st.lock_sel), .wlatch(st.wlatch),
        .sr_lock_en(st.sr_lock_en), .guard_n(guard_n),
        .arr_ok(arr_ok), .stat_ok(stat_ok)
    );

endmodule

// File: tb/test_spi_mem_ctrl.sv
`timescale 1ns/1ps
module test_spi_mem_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, guard_n = 1'b1;
    logic        miso, miso_oe, mem_we, mem_re;
    logic [10:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [7:0]  mem [2048];
    logic [7:0]  exp_mem [2048];
    int          n_chk = 0, n_fail = 0;
    logic        e_wl = 0, e_fl = 0, e_pen = 0;
    logic [1:0]  e_bl = 0, e_wd = 0;

    always #2 clk = ~clk;

    spi_mem_ctrl i_spi_mem_ctrl (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .guard_n(guard_n),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    // Synchronous memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic locked(input logic [10:0] a, input logic [1:0] bl);
        case (bl)
            2'd0: return 1'b0;
            2'd1: return a >= 11'h600;
            2'd2: return a >= 11'h400;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] e_stat();
        return {e_pen, 1'b0, e_fl, e_wd, e_bl, e_wl};
    endfunction

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            tick(4);
            rx[i] = miso;
            sck = 1'b1;
            tick(4);
            sck = 1'b0;
        end
    endtask

    task automatic cs_on();
        cs_n = 1'b0;
        tick(2);
    endtask

    task automatic cs_off();
        tick(2);
        cs_n = 1'b1;
        tick(4);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        cs_on(); xbyte(op, r); cs_off();
        if (op == 8'h06) e_wl = 1'b1;
        if (op == 8'h00) e_fl = 1'b1;
        if (op == 8'h04) begin e_wl = 1'b0; e_fl = 1'b0; end
    endtask

    task automatic rd_stat(output logic [7:0] s);
        logic [7:0] r;
        cs_on(); xbyte(8'h05, r); xbyte(8'h00, s); cs_off();
    endtask

    task automatic wr_stat(input logic [7:0] v);
        logic [7:0] r;
        cs_on(); xbyte(8'h01, r); xbyte(v, r); cs_off();
        if (e_wl && (!e_pen || guard_n)) begin
            e_pen = v[7]; e_wd = v[4:3]; e_bl = v[2:1];
        end
        e_wl = 1'b0;
    endtask

    task automatic arr_wr(input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1);
        logic [7:0]  r;
        logic [10:0] p;
        cs_on(); xbyte(8'h02, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
        xbyte(d0, r); xbyte(d1, r); cs_off();
        for (int k = 0; k < 2; k++) begin
            p = a[10:0] + 11'(k);
            if (e_wl && !locked(p, e_bl)) exp_mem[p] = (k == 0) ? d0 : d1;
        end
        e_wl = 1'b0;
    endtask

    task automatic arr_rd(input logic [15:0] a, output logic [7:0] d0, output logic [7:0] d1);
        logic [7:0] r;
        cs_on(); xbyte(8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
        xbyte(8'h00, d0); xbyte(8'h00, d1); cs_off();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got running expected finished");
        finish_run();
    end

    initial begin
        logic [7:0]  s, d0, d1, s1, s2;
        logic [10:0] starts [3];
        logic [10:0] p;
        string       tag;
        starts[0] = 11'h3FF; starts[1] = 11'h5FF; starts[2] = 11'h7FF;
        for (int i = 0; i < 2048; i++) begin
            mem[i] = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        tick(6);
        rst_n = 1'b1;
        tick(2);

        // Reset state.
        chk("R1 idle pad enable", {7'd0, miso_oe}, 8'h00);
        rd_stat(s); chk("R2 reset status", s, 8'h00);

        // Latch and flag commands.
        cmd1(8'h06); rd_stat(s); chk("R2 arm", s, e_stat());
        cmd1(8'h00); rd_stat(s); chk("R2 flag set", s, 8'h21);
        cmd1(8'h04); rd_stat(s); chk("R2 disarm clears both", s, 8'h00);

        // Partial byte dropped; pad enabled while selected.
        cs_on();
        chk("R1 pad enable selected", {7'd0, miso_oe}, 8'h01);
        for (int i = 7; i >= 4; i--) begin
            mosi = (i == 2 || i == 1); tick(4); sck = 1'b1; tick(4); sck = 1'b0;
        end
        cs_off();
        rd_stat(s); chk("R1 partial byte", s, 8'h00);

        // Unknown and trailing bytes ignored.
        cmd1(8'hAB); rd_stat(s); chk("R11 unknown opcode", s, 8'h00);
        cs_on(); xbyte(8'h06, s); xbyte(8'h04, s); cs_off(); e_wl = 1'b1;
        rd_stat(s); chk("R11 trailing byte", s, 8'h01);

        // Latch survives reads and aborted writes.
        arr_rd(16'h0010, d0, d1); rd_stat(s); chk("R10 kept after read", s, 8'h01);
        cs_on(); xbyte(8'h02, s); xbyte(8'h00, s); xbyte(8'h10, s); cs_off();
        rd_stat(s); chk("R10 kept after bare address", s, 8'h01);
        cmd1(8'h04);

        // Read stream, wrap and ignored upper address bits.
        arr_rd(16'h07FF, d0, d1);
        chk("R4 read top", d0, exp_mem[11'h7FF]);
        chk("R4 read wrap", d1, exp_mem[11'h000]);
        arr_rd(16'hF9FF, d0, d1);
        chk("R4 upper bits ignored", d0, exp_mem[11'h1FF]);
        chk("R4 increment", d1, exp_mem[11'h200]);

        // Repeated status bytes.
        cmd1(8'h00);
        cs_on(); xbyte(8'h05, s); xbyte(8'h00, s1); xbyte(8'h00, s2); cs_off();
        chk("R3 status first", s1, 8'h20);
        chk("R3 status repeat", s2, 8'h20);
        cmd1(8'h04);

        // Sweep lock selector, status lock, guard and latch.
        for (int c = 0; c < 32; c++) begin
            logic [1:0] bl;
            logic       pen, gn, wl;
            bl = c[1:0]; pen = c[2]; gn = c[3]; wl = c[4];
            guard_n = 1'b1;
            cmd1(8'h06);
            wr_stat({pen, 2'b00, bl, bl, 1'b0});
            rd_stat(s); chk("R9 setup status", s, e_stat());
            guard_n = gn;
            for (int j = 0; j < 3; j++) begin
                if (wl) cmd1(8'h06);
                arr_wr({5'b0, starts[j]}, {3'(j), 5'(c)}, {3'(j + 4), 5'(c)});
            end
            rd_stat(s); chk("R10 cleared after array write", s, e_stat());
            for (int j = 0; j < 3; j++) begin
                arr_rd({5'b0, starts[j]}, d0, d1);
                for (int k = 0; k < 2; k++) begin
                    p = starts[j] + 11'(k);
                    tag = !wl ? "R7 array" : (locked(p, bl) ? "R6 array" : "R5 array");
                    if (wl && pen && !gn && !locked(p, bl)) tag = "R8 array";
                    chk(tag, (k == 0) ? d0 : d1, exp_mem[p]);
                end
            end
            if (wl) cmd1(8'h06);
            tag = !wl ? "R7 status" : ((pen && !gn) ? "R8 status" : "R9 status");
            wr_stat({~pen, 1'b0, 1'b1, ~bl, ~bl, 1'b1});
            rd_stat(s); chk(tag, s, e_stat());
        end

        finish_run();
    end

endmodule